// File: doc/BRIEF.md
# Multi-bank programmable clock divider

This block takes one fast source clock and derives four divided clocks from it: three output banks (A, B, C) and one feedback clock. A shared prescaler divides first. Each of the four chains then applies its own post-divide, which static select inputs choose. Every divided clock is modelled as a single net, and the block is fully synchronous to the source clock. The chains advance on a base tick. In normal mode the base tick comes on every source cycle. In bypass mode it comes on each synchronised rising edge of a selected reference input.

Select changes are latched only at the common alignment point of all counters. A synchronous stop parks the three banks low without shortening any pulse, while the feedback clock keeps running. An active-low run/enable input clears every counter and drops the pad output enable. When it rises again, all four outputs start together.

Top module: `multi_bank_clk_div`

## Requirements
- R1: While `run_i` is low, `pad_oe_o` is low one cycle later and all four clock outputs are low. On the first base tick after `run_i` rises, all four outputs go high in the same cycle.
- R2: The prescaler divides base ticks by 2 when `pre_sel_i`=0 and by 4 when `pre_sel_i`=1.
- R3: Banks A and B post-divide by 2 when their select is 0 and by 4 when it is 1. Their total ratios are therefore 4, 8, 8 or 16.
- R4: Bank C post-divides by 4 when `sel_c_i`=0 and by 6 when it is 1, giving total ratios of 8, 12, 16 or 24.
- R5: The feedback post-divide is selected by `fb_sel_i`: 0 gives 4, 1 gives 8, 2 gives 6 and 3 gives 12.
- R6: Every output is high for exactly half of its period, counted in source cycles.
- R7: While `stop_ni` is low, banks A to C go low only after their current high half has ended, then stay low. The feedback output keeps toggling.
- R8: After `stop_ni` returns high, a stopped bank resumes only at the start of a new period, with a full-length high half.
- R9: Select inputs are sampled only at the alignment point, which comes every 24 prescaled ticks, and at the first tick after restart. Every chain starts a new period at that point, so no output ever emits a truncated cycle.
- R10: Dropping `run_i` mid-operation clears all phase state. After re-enable the outputs restart in phase, exactly as after reset.
- R11: When `fast_src_i` is low, the chains advance once per rising edge of the selected reference. The edge is seen through a two-stage synchroniser.
- R12: `ref_sel_i`=1 selects `ref1_i` and `ref_sel_i`=0 selects `ref0_i`. Edges on the reference that is not selected have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | High: run. Low: clear dividers and disable pads |
| fast_src_i | input | 1 | High: tick every source cycle. Low: bypass from reference |
| ref_sel_i | input | 1 | Reference choice (1 = ref1_i) |
| ref0_i | input | 1 | Reference input 0 |
| ref1_i | input | 1 | Reference input 1 |
| pre_sel_i | input | 1 | Prescaler select (0: /2, 1: /4) |
| sel_a_i | input | 1 | Bank A post-divide select |
| sel_b_i | input | 1 | Bank B post-divide select |
| sel_c_i | input | 1 | Bank C post-divide select |
| fb_sel_i | input | 2 | Feedback post-divide select |
| stop_ni | input | 1 | Active-low synchronous bank stop |
| bank_a_o | output | 1 | Bank A clock |
| bank_b_o | output | 1 | Bank B clock |
| bank_c_o | output | 1 | Bank C clock |
| fb_o | output | 1 | Feedback clock |
| pad_oe_o | output | 1 | Output enable for the pad drivers |

## Verification
A counter out of step with the shared alignment counter shows up as an output edge that misses a common rising point. It also shows up as a high or low half of the wrong length, and both appear within one output period of the fault. A select latched at the wrong moment produces a truncated cycle on the next tick. A stop gate set or cleared at the wrong moment produces a shortened pulse on a bank at the start or end of the stop window. Because every output is compared with a behavioural model on every cycle, any such error is reported within the cycle in which it reaches a port.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  localparam int NUM_CH = 4;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;
  localparam int CH_C   = 2;
  localparam int CH_FB  = 3;
  localparam int MAX_PRE = 4;

  typedef struct packed {
    logic       pre;
    logic       a;
    logic       b;
    logic       c;
    logic [1:0] fb;
  } cdiv_cfg_t;

  function automatic int pre_ratio(input logic s);
    return s ? 4 : 2;
  endfunction

  function automatic int post_ratio(input int ch, input cdiv_cfg_t cfg);
    int r;
    case (ch)
      CH_A:    r = cfg.a ? 4 : 2;
      CH_B:    r = cfg.b ? 4 : 2;
      CH_C:    r = cfg.c ? 6 : 4;
      default: begin
        case (cfg.fb)
          2'd0:    r = 4;
          2'd1:    r = 8;
          2'd2:    r = 6;
          default: r = 12;
        endcase
      end
    endcase
    return r;
  endfunction

  function automatic int gcd(input int x, input int y);
    int a = x;
    int b = y;
    int t;
    while (b != 0) begin
      t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  function automatic cdiv_cfg_t code_cfg(input int k);
    cdiv_cfg_t c;
    c    = '0;
    c.a  = k[0];
    c.b  = k[0];
    c.c  = k[0];
    c.fb = k[1:0];
    return c;
  endfunction

  // common period of all post-divides, in prescaled ticks
  function automatic int calc_align();
    int l = 1;
    int p;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int k = 0; k < 4; k++) begin
        p = post_ratio(ch, code_cfg(k));
        l = (l / gcd(l, p)) * p;
      end
    end
    return l;
  endfunction

  function automatic int calc_max_post();
    int m = 0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int k = 0; k < 4; k++) begin
        if (post_ratio(ch, code_cfg(k)) > m) m = post_ratio(ch, code_cfg(k));
      end
    end
    return m;
  endfunction

  localparam int ALIGN_LEN = calc_align();
  localparam int MAX_POST  = calc_max_post();

endpackage

// File: rtl/cdiv_tick_src.sv
module cdiv_tick_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_src_i,
  input  logic ref_sel_i,
  input  logic ref0_i,
  input  logic ref1_i,
  output logic tick_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;
  logic         ref_mux;

  assign ref_mux = ref_sel_i ? ref1_i : ref0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], ref_mux};
      prev_q <= sync_q[MSB];
    end
  end

  assign tick_o = fast_src_i | (sync_q[MSB] & ~prev_q);

endmodule

// File: rtl/cdiv_ctrl.sv
module cdiv_ctrl
  import cdiv_pkg::*;
#(
  parameter int ALIGN = ALIGN_LEN
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic      base_tick_i,
  input  cdiv_cfg_t cfg_i,
  output cdiv_cfg_t cfg_o,
  output logic      pre_tick_o,
  output logic      restart_o,
  output logic      align_o,
  output logic      oe_o
);
  localparam int PRE_W = $clog2(MAX_PRE);
  localparam int AL_W  = $clog2(ALIGN);

  logic             fresh_q;
  logic [PRE_W-1:0] pre_cnt_q;
  logic [AL_W-1:0]  align_q;
  cdiv_cfg_t        cfg_q;
  logic             oe_q;
  logic             pre_last, al_last, pre_tick, load;

  assign pre_last = pre_cnt_q == PRE_W'(pre_ratio(cfg_q.pre) - 1);
  assign al_last  = align_q == AL_W'(ALIGN - 1);
  assign pre_tick = base_tick_i & (fresh_q | pre_last);
  assign load     = pre_tick & (fresh_q | al_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fresh_q   <= 1'b1;
      pre_cnt_q <= '0;
      align_q   <= '0;
      cfg_q     <= '0;
      oe_q      <= 1'b0;
    end else begin
      oe_q <= run_i;
      if (!run_i) begin
        fresh_q   <= 1'b1;
        pre_cnt_q <= '0;
        align_q   <= '0;
      end else if (base_tick_i) begin
        fresh_q   <= 1'b0;
        pre_cnt_q <= pre_tick ? '0 : pre_cnt_q + 1'b1;
        if (pre_tick) align_q <= load ? '0 : align_q + 1'b1;
        if (load) cfg_q <= cfg_i;
      end
    end
  end

  assign cfg_o      = cfg_q;
  assign pre_tick_o = pre_tick;
  assign restart_o  = fresh_q;
  assign align_o    = load;
  assign oe_o       = oe_q;

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(pre_cnt_q) < pre_ratio(cfg_q.pre)); // R2
  AST_ALIGN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(align_q) < ALIGN); // R9

endmodule

// File: rtl/cdiv_chain.sv
module cdiv_chain #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             align_i,
  input  logic [CNT_W-1:0] post_i,
  input  logic             stop_req_i,
  output logic             clk_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n, half;
  logic             lvl_q, lvl_n, gate_q, gate_n, out_q;
  logic             wrap;

  assign wrap  = restart_i | (cnt_q == post_i - 1'b1);
  assign cnt_n = wrap ? '0 : cnt_q + 1'b1;
  assign half  = post_i >> 1;
  assign lvl_n = cnt_n < half;

  // set only from a low half, clear only at a period start
  assign gate_n = gate_q ? ~(wrap & ~stop_req_i) : (stop_req_i & ~lvl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else if (tick_i) begin
      cnt_q  <= cnt_n;
      lvl_q  <= lvl_n;
      gate_q <= gate_n;
      out_q  <= lvl_n & ~gate_n;
    end
  end

  assign clk_o = out_q;

  AST_ALIGN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && align_i) |-> wrap); // R9
  AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_q) |-> (cnt_q == '0)); // R8
  AST_NO_CUT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_q) |-> $fell(lvl_q)); // R7
  AST_OUT_WITHIN_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q |-> lvl_q); // R7

endmodule

// File: rtl/multi_bank_clk_div.sv
module multi_bank_clk_div
  import cdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       fast_src_i,
  input  logic       ref_sel_i,
  input  logic       ref0_i,
  input  logic       ref1_i,
  input  logic       pre_sel_i,
  input  logic       sel_a_i,
  input  logic       sel_b_i,
  input  logic       sel_c_i,
  input  logic [1:0] fb_sel_i,
  input  logic       stop_ni,
  output logic       bank_a_o,
  output logic       bank_b_o,
  output logic       bank_c_o,
  output logic       fb_o,
  output logic       pad_oe_o
);
  localparam int CNT_W = $clog2(MAX_POST + 1);

  logic              base_tick, pre_tick, restart, align;
  cdiv_cfg_t         cfg_in, cfg_q;
  logic [NUM_CH-1:0] ch_clk;

  assign cfg_in = '{pre: pre_sel_i, a: sel_a_i, b: sel_b_i, c: sel_c_i, fb: fb_sel_i};

  cdiv_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fast_src_i (fast_src_i),
    .ref_sel_i  (ref_sel_i),
    .ref0_i     (ref0_i),
    .ref1_i     (ref1_i),
    .tick_o     (base_tick)
  );

  cdiv_ctrl #(.ALIGN(ALIGN_LEN)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .base_tick_i (base_tick),
    .cfg_i       (cfg_in),
    .cfg_o       (cfg_q),
    .pre_tick_o  (pre_tick),
    .restart_o   (restart),
    .align_o     (align),
    .oe_o        (pad_oe_o)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chain
    logic [CNT_W-1:0] post;
    logic             stop_req;
    assign post     = CNT_W'(post_ratio(ch, cfg_q));
    assign stop_req = (ch != CH_FB) && !stop_ni;

    cdiv_chain #(.CNT_W(CNT_W)) u_chain (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_i),
      .tick_i     (pre_tick),
      .restart_i  (restart),
      .align_i    (align),
      .post_i     (post),
      .stop_req_i (stop_req),
      .clk_o      (ch_clk[ch])
    );
  end

  assign bank_a_o = ch_clk[CH_A];
  assign bank_b_o = ch_clk[CH_B];
  assign bank_c_o = ch_clk[CH_C];
  assign fb_o     = ch_clk[CH_FB];

endmodule

// File: tb/multi_bank_clk_div_tb.sv
`timescale 1ns/1ps
module multi_bank_clk_div_tb;
  localparam int S = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic run_i = 1'b0, fast_src_i = 1'b1, ref_sel_i = 1'b0, ref0_i = 1'b0, ref1_i = 1'b0;
  logic pre_sel_i = 1'b0, sel_a_i = 1'b0, sel_b_i = 1'b0, sel_c_i = 1'b0, stop_ni = 1'b1;
  logic [1:0] fb_sel_i = 2'd0;
  logic bank_a_o, bank_b_o, bank_c_o, fb_o, pad_oe_o;

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit cmp_en = 1'b0;
  bit ref_on = 1'b0;
  int ref_cnt = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  multi_bank_clk_div #(.SYNC_STAGES(S)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .fast_src_i(fast_src_i),
    .ref_sel_i(ref_sel_i), .ref0_i(ref0_i), .ref1_i(ref1_i), .pre_sel_i(pre_sel_i),
    .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .sel_c_i(sel_c_i), .fb_sel_i(fb_sel_i),
    .stop_ni(stop_ni), .bank_a_o(bank_a_o), .bank_b_o(bank_b_o), .bank_c_o(bank_c_o),
    .fb_o(fb_o), .pad_oe_o(pad_oe_o)
  );

  function automatic int outv(input int ch);
    case (ch)
      0: return int'(bank_a_o);
      1: return int'(bank_b_o);
      2: return int'(bank_c_o);
      default: return int'(fb_o);
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit hist[$];
  bit m_fresh, m_oe;
  int m_pos, m_pre;
  int m_post[4];
  bit m_lvl[4], m_gate[4], m_out[4];

  function automatic int want_post(input int ch);
    case (ch)
      0: return sel_a_i ? 4 : 2;
      1: return sel_b_i ? 4 : 2;
      2: return sel_c_i ? 6 : 4;
      default: begin
        case (fb_sel_i)
          2'd0: return 4;
          2'd1: return 8;
          2'd2: return 6;
          default: return 12;
        endcase
      end
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = {};
      for (int i = 0; i < S + 2; i++) hist.push_back(1'b0);
      m_fresh = 1'b1; m_oe = 1'b0; m_pos = 0; m_pre = 2;
      for (int c = 0; c < 4; c++) begin
        m_post[c] = 2; m_lvl[c] = 0; m_gate[c] = 0; m_out[c] = 0;
      end
    end else begin
      bit tick, ld;
      hist.push_back(ref_sel_i ? ref1_i : ref0_i);
      void'(hist.pop_front());
      tick = fast_src_i || (hist[1] && !hist[0]);
      m_oe = run_i;
      if (!run_i) begin
        m_fresh = 1'b1; m_pos = 0;
        for (int c = 0; c < 4; c++) begin
          m_lvl[c] = 0; m_gate[c] = 0; m_out[c] = 0;
        end
      end else if (tick) begin
        ld = m_fresh;
        if (m_fresh) m_pos = 0;
        else begin
          m_pos++;
          if (m_pos == m_pre * 24) begin ld = 1; m_pos = 0; end
        end
        m_fresh = 1'b0;
        if (ld) begin
          m_pre = pre_sel_i ? 4 : 2;
          for (int c = 0; c < 4; c++) m_post[c] = want_post(c);
        end
        if (m_pos % m_pre == 0) begin
          for (int c = 0; c < 4; c++) begin
            int n;
            bit lv, st, at_start;
            n = m_pre * m_post[c];
            lv = (m_pos % n) < n / 2;
            at_start = (m_pos % n) == 0;
            st = (c < 3) && !stop_ni;
            if (m_gate[c]) m_gate[c] = !(at_start && !st);
            else m_gate[c] = st && !m_lvl[c];
            m_lvl[c] = lv;
            m_out[c] = lv && !m_gate[c];
          end
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (cmp_en) begin
      chk(cur_req, "pad_oe_o", int'(pad_oe_o), int'(m_oe));
      for (int c = 0; c < 4; c++) chk(cur_req, $sformatf("out%0d", c), outv(c), int'(m_out[c]));
    end
  end

  // reference toggler: period 4 source cycles
  always @(negedge clk_i) begin
    if (ref_on) begin
      ref_cnt++;
      if (ref_cnt == 2) begin ref_cnt = 0; ref1_i = ~ref1_i; end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic measure(input int ch, output int per, output int hi);
    int prev, cur, guard;
    bit rose;
    per = 0; hi = 0; guard = 0;
    prev = outv(ch);
    do begin
      @(negedge clk_i); cur = outv(ch); rose = (prev == 0 && cur == 1); prev = cur; guard++;
    end while (!rose && guard < 400);
    do begin
      hi += cur; per++;
      @(negedge clk_i); cur = outv(ch); rose = (prev == 0 && cur == 1); prev = cur; guard++;
    end while (!rose && guard < 900);
  endtask

  task automatic expect_ratio(input string req, input int ch, input int ratio);
    int per, hi;
    measure(ch, per, hi);
    chk(req, $sformatf("period ch%0d", ch), per, ratio);
    chk("R6", $sformatf("high half ch%0d", ch), hi, ratio / 2);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int togg, ones, prev;
    int snap[4];
    // R1: reset state
    cycles(4);
    chk("R1", "oe in reset", int'(pad_oe_o), 0);
    for (int c = 0; c < 4; c++) chk("R1", $sformatf("out%0d in reset", c), outv(c), 0);
    rst_ni = 1'b1;
    cmp_en = 1'b1;
    cycles(3);
    // R1: common first rise
    run_i = 1'b1;
    cycles(1);
    chk("R1", "oe after run", int'(pad_oe_o), 1);
    for (int c = 0; c < 4; c++) chk("R1", $sformatf("out%0d first rise", c), outv(c), 1);

    cur_req = "R3";
    expect_ratio("R3", 0, 4);
    expect_ratio("R3", 1, 4);
    expect_ratio("R4", 2, 8);
    expect_ratio("R5", 3, 8);

    cur_req = "R2";
    pre_sel_i = 1'b1; sel_a_i = 1'b1; sel_c_i = 1'b1; fb_sel_i = 2'd3;
    cycles(150);
    expect_ratio("R2", 1, 8);
    expect_ratio("R3", 0, 16);
    expect_ratio("R4", 2, 24);
    expect_ratio("R5", 3, 48);

    cur_req = "R5";
    pre_sel_i = 1'b0; fb_sel_i = 2'd2;
    cycles(150);
    expect_ratio("R5", 3, 12);
    expect_ratio("R4", 2, 12);
    fb_sel_i = 2'd1;
    cycles(120);
    expect_ratio("R5", 3, 16);

    // R7: stop holds banks low, feedback keeps running
    cur_req = "R7";
    @(negedge clk_i); stop_ni = 1'b0;
    cycles(40);
    ones = 0; togg = 0; prev = outv(3);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      ones += outv(0) + outv(1) + outv(2);
      if (outv(3) != prev) togg++;
      prev = outv(3);
    end
    chk("R7", "bank highs during stop", ones, 0);
    chk("R7", "feedback toggles during stop", int'(togg >= 2), 1);
    // R8: release gives full pulses
    cur_req = "R8";
    stop_ni = 1'b1;
    expect_ratio("R8", 0, 8);
    // stop asserted mid high half, at odd offsets
    for (int k = 0; k < 5; k++) begin
      cycles(3 + k);
      stop_ni = 1'b0;
      cycles(7 + 2 * k);
      stop_ni = 1'b1;
    end
    cycles(60);

    // R9: selects changed at arbitrary points
    cur_req = "R9";
    for (int k = 0; k < 6; k++) begin
      cycles(5 + 7 * k);
      sel_a_i = ~sel_a_i; sel_c_i = ~sel_c_i; fb_sel_i = fb_sel_i + 2'd1;
      if (k == 3) pre_sel_i = 1'b1;
    end
    cycles(250);
    pre_sel_i = 1'b0; sel_a_i = 1'b0; sel_b_i = 1'b0; sel_c_i = 1'b0; fb_sel_i = 2'd0;
    cycles(150);

    // R10: run low clears, restart in phase
    cur_req = "R10";
    cycles(3);
    run_i = 1'b0;
    cycles(1);
    chk("R10", "oe after run low", int'(pad_oe_o), 0);
    for (int c = 0; c < 4; c++) chk("R10", $sformatf("out%0d cleared", c), outv(c), 0);
    cycles(4);
    run_i = 1'b1;
    cycles(1);
    for (int c = 0; c < 4; c++) chk("R10", $sformatf("out%0d restart rise", c), outv(c), 1);
    cycles(20);

    // R11: bypass from reference 1
    cur_req = "R11";
    ref_sel_i = 1'b1; ref_on = 1'b1;
    cycles(2);
    fast_src_i = 1'b0;
    cycles(20);
    expect_ratio("R11", 0, 16);
    expect_ratio("R11", 2, 32);

    // R12: unselected reference edges ignored
    cur_req = "R12";
    ref_sel_i = 1'b0;
    cycles(6);
    for (int c = 0; c < 4; c++) snap[c] = outv(c);
    cycles(40);
    for (int c = 0; c < 4; c++) chk("R12", $sformatf("out%0d frozen", c), outv(c), snap[c]);
    ref_sel_i = 1'b1;
    cycles(20);
    expect_ratio("R12", 0, 16);

    cmp_en = 1'b0;
    finish_run();
  end

endmodule